// File: doc/BRIEF.md
# DRAM Read Parity Error Trap

This block watches every DRAM read on a shared memory data path and tests each enabled byte lane for odd parity. Four masters can read memory: the processor, an add-on expansion module, the VME bridge and the SCSI controller. Each one has its own read strobe. When a checked read fails, the block records which master made it in a sticky flag.

The block answers in one of two ways, depending on the master. The processor and the expansion module are still waiting on the cycle, so they receive a bus-error pulse. The VME bridge and the SCSI controller cannot take a bus error, so a failure on their reads raises a level-7 interrupt request instead. Software reads an 8-bit status byte to find which masters failed, and that read clears the flags.

A strap input tells the block whether parity storage is fitted. The strap value appears in the status byte, and while it is low no error is ever reported.

Top module: `parity_trap`

## Requirements
- R1: A byte lane fails when its 8 data bits and its parity bit hold an even number of ones (odd parity), and only lanes whose `byte_en` bit is high are tested.
- R2: A failing read with `rd_strobe[2]` (VME bridge) or `rd_strobe[3]` (SCSI controller) high sets `status[2]` or `status[3]` respectively, visible from the next clock edge.
- R3: A failing read with `rd_strobe[0]` (processor) or `rd_strobe[1]` (expansion module) sets `status[0]` or `status[1]` and drives `berr` high for exactly the one cycle after the strobe cycle; it never raises `irq7`.
- R4: Source flags `status[3:0]` stay set until a status read.
- R5: While `stat_rd` is high, `status` shows the current flags, and those flags are clear from the next edge; an error caught in that same cycle is still recorded.
- R6: `irq7` is high exactly while `status[2]` or `status[3]` is set.
- R7: `status[4]` mirrors `par_fitted`; while it is low, no flag, `berr` or `irq7` is produced.
- R8: `status[7:5]` always read zero, and reset clears all flags, `berr` and `irq7`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_fitted | input | 1 | Strap: parity storage present |
| rd_strobe | input | 4 | Per-master read strobe: 0 processor, 1 expansion, 2 VME bridge, 3 SCSI |
| rd_data | input | BYTES*8 | DRAM read data |
| rd_par | input | BYTES | DRAM read parity bit for each byte |
| byte_en | input | BYTES | Byte lanes active on this read |
| stat_rd | input | 1 | Status byte read strobe, clears the flags |
| irq7 | output | 1 | Level-7 interrupt request |
| berr | output | 1 | Bus-error response to processor or expansion master |
| status | output | 8 | {3'b0, par_fitted, SCSI, VME, expansion, processor} |

## Verification
The assertions check the following on every cycle:
- flags stay set until a read, and a read clears them;
- `irq7` holds while a bridge or SCSI flag is set, and appears only after a bridge or SCSI read;
- `berr` follows only a processor or expansion strobe;
- the strap bit and the reserved bits of the status byte.

Only the bench scenarios can show whether a given data and parity pattern counts as a failure. These cover odd and even patterns across byte-enable masks, errors that arrive in the same cycle as a read, and the quiet behaviour with the strap low. For these the bench's reference model predicts every output on every cycle.

// File: rtl/parity_trap.sv
module parity_trap #(
  parameter int BYTES = 4,
  localparam int DW = BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_fitted,
  input  logic [3:0]       rd_strobe,
  input  logic [DW-1:0]    rd_data,
  input  logic [BYTES-1:0] rd_par,
  input  logic [BYTES-1:0] byte_en,
  input  logic             stat_rd,
  output logic             irq7,
  output logic             berr,
  output logic [7:0]       status
);
  logic [BYTES-1:0] lane_bad;
  logic [3:0]       flags, hit;
  logic             any_bad;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign lane_bad[b] = byte_en[b] & ~(^{rd_data[b*8 +: 8], rd_par[b]});
  end

  assign any_bad = par_fitted & (|lane_bad);
  assign hit     = rd_strobe & {4{any_bad}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      berr  <= 1'b0;
    end else begin
      flags <= (stat_rd ? 4'b0 : flags) | hit;
      berr  <= |hit[1:0];
    end
  end

  assign irq7   = |flags[3:2];
  assign status = {3'b000, par_fitted, flags};
endmodule

// File: rtl/parity_trap_chk.sv
module parity_trap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       par_fitted,
  input logic [3:0] rd_strobe,
  input logic       stat_rd,
  input logic       irq7,
  input logic       berr,
  input logic [7:0] status
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd) |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0]))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && rd_strobe == 4'b0) |=> (status[3:0] == 4'b0)); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq7 && !stat_rd) |=> irq7); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq7 && rd_strobe[3:2] == 2'b00) |=> !irq7); // R2
  AST_BERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> $past(|rd_strobe[1:0])); // R3
  AST_STRAP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] == par_fitted); // R7
  AST_NO_ERR_UNFITTED: assert property (@(posedge clk) disable iff (!rst_n)
    !par_fitted |=> !berr); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == 3'b000); // R8
endmodule

bind parity_trap parity_trap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .par_fitted(par_fitted), .rd_strobe(rd_strobe),
  .stat_rd(stat_rd), .irq7(irq7), .berr(berr), .status(status)
);

// File: tb/sim_parity_trap.sv
module sim_parity_trap;
  logic        clk = 0, rst_n = 0, par_fitted = 1, stat_rd = 0;
  logic [3:0]  rd_strobe = 0, rd_par = 0, byte_en = 0;
  logic [31:0] rd_data = 0;
  logic        irq7, berr;
  logic [7:0]  status;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] m_flags = 0;
  logic       m_berr = 0;

  parity_trap u0 (.clk(clk), .rst_n(rst_n), .par_fitted(par_fitted), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rd_par(rd_par), .byte_en(byte_en), .stat_rd(stat_rd),
    .irq7(irq7), .berr(berr), .status(status));

  always #2 clk = ~clk;

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ~(^d[b*8 +: 8]);
    return p;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [3:0] s, input logic [31:0] d,
                     input logic [3:0] p, input logic [3:0] be, input logic rd);
    int ones;
    logic bad;
    logic [3:0] hit;
    rd_strobe = s; rd_data = d; rd_par = p; byte_en = be; stat_rd = rd;
    #1;
    chk({tag, " status"}, status, {3'b000, par_fitted, m_flags});
    chk({tag, " irq7"}, {7'b0, irq7}, {7'b0, m_flags[2] | m_flags[3]});
    chk({tag, " berr"}, {7'b0, berr}, {7'b0, m_berr});
    bad = 0;
    for (int b = 0; b < 4; b++) begin
      ones = $countones({d[b*8 +: 8], p[b]});
      if (be[b] && (ones % 2 == 0)) bad = 1;
    end
    hit = (par_fitted && bad) ? s : 4'b0;
    @(posedge clk);
    m_flags = (rd ? 4'b0 : m_flags) | hit;
    m_berr = hit[0] | hit[1];
    @(negedge clk);
  endtask

  task automatic do_reset(input logic fit);
    rst_n = 0; par_fitted = fit;
    rd_strobe = 0; stat_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_flags = 0; m_berr = 0;
    chk("R8 reset status", status, {3'b000, fit, 4'b0});
    chk("R8 reset outputs", {6'b0, irq7, berr}, 8'h00);
  endtask

  initial begin
    logic [31:0] d;
    d = 32'hA5_3C_0F_81;
    @(negedge clk);
    do_reset(1);
    cyc("R1 good parity cpu", 4'b0001, d, good_par(d), 4'hF, 0);
    cyc("R1 idle", 4'b0000, 0, 0, 0, 0);
    cyc("R3 cpu error", 4'b0001, d, good_par(d) ^ 4'b0100, 4'hF, 0);
    cyc("R3 berr pulse", 4'b0000, 0, 0, 0, 0);
    cyc("R3 berr ends", 4'b0000, 0, 0, 0, 0);
    cyc("R3 expansion error", 4'b0010, d, good_par(d) ^ 4'b0001, 4'b0001, 0);
    cyc("R4 sticky", 4'b0000, 0, 0, 0, 0);
    cyc("R5 read", 4'b0000, 0, 0, 0, 1);
    cyc("R5 cleared", 4'b0000, 0, 0, 0, 0);
    cyc("R1 masked lane", 4'b0100, d, good_par(d) ^ 4'b1000, 4'b0111, 0);
    cyc("R2 vme error", 4'b0100, d, good_par(d) ^ 4'b1000, 4'b1000, 0);
    cyc("R6 irq held", 4'b0000, 0, 0, 0, 0);
    cyc("R2 scsi error", 4'b1000, 32'h0, 4'h0, 4'h3, 0);
    cyc("R6 irq both", 4'b0000, 0, 0, 0, 0);
    cyc("R5 read with new error", 4'b1000, 32'hFF, 4'b0000, 4'b0001, 1);
    cyc("R5 kept error", 4'b0000, 0, 0, 0, 0);
    cyc("R5 read again", 4'b0000, 0, 0, 0, 1);
    cyc("R6 irq dropped", 4'b0000, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      d = 32'h1234_5678 * (i + 3) ^ (i << 9);
      cyc("R1 sweep", 4'(1 << (i % 4)), d, good_par(d) ^ 4'(i / 4), 4'(i * 7), (i % 5) == 4);
    end
    do_reset(0);
    cyc("R7 unfitted cpu", 4'b0001, d, ~good_par(d), 4'hF, 0);
    cyc("R7 unfitted scsi", 4'b1000, d, ~good_par(d), 4'hF, 0);
    cyc("R7 no response", 4'b0000, 0, 0, 0, 0);
    do_reset(1);
    cyc("R8 after reset", 4'b0000, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule